// File: doc/BRIEF.md
# Parallel-Prefix 8-Bit ALU

This block is a purely combinational arithmetic/logic unit for two 8-bit operands. A 2-bit select chooses bitwise AND, bitwise XOR or unsigned addition. The block drives an 8-bit result and a carry flag. It has no clock and no reset. Every output follows its inputs within the same evaluation.

The addition path is a Kogge-Stone parallel-prefix adder with three parts:

- A per-bit stage forms propagate (a XOR b) and generate (a AND b).
- A carry network of log2(width) levels merges these into group terms. The spans double at each level: 1, 2, then 4.
- A sum stage XORs each propagate bit with the carry into that position.

There is no external carry-in. A three-way selector then picks among the AND, XOR and sum words.

Top module: `alu_kogge8`

## Requirements
- R1: With `op_sel` = 2'b00 the result is the bitwise AND of the operands and `carry_out` is 0.
- R2: With `op_sel` = 2'b01 the result is the bitwise XOR of the operands and `carry_out` is 0.
- R3: With `op_sel` = 2'b10, {`carry_out`, `result`} equals the 9-bit unsigned sum of the two operands.
- R4: With `op_sel` = 2'b11 both `result` and `carry_out` are 0, whatever the operands.
- R5: Adding 8'b10101111 and 8'b10000101 gives 8'b00110100 with `carry_out` = 1.
- R6: XOR of 8'b10101001 and 8'b10000000 gives 8'b00101001.
- R7: The carry into bit 0 is zero, so 0 + 0 gives 0 with no carry. A carry generated at bit 0 crosses every propagate position: 8'hFF + 8'h01 gives 8'h00 with `carry_out` = 1.
- R8: The outputs change in the same time step as the inputs, with no clock edge involved.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 8 | First operand |
| opnd_b | input | 8 | Second operand |
| op_sel | input | 2 | Operation code: 00 AND, 01 XOR, 10 ADD, 11 zero output |
| result | output | 8 | Selected operation result |
| carry_out | output | 1 | Carry from the top bit; meaningful for ADD only |

## Verification
The embedded immediate checks assume the operands and select are two-state. They also assume the checks are evaluated after the combinational cone has settled, so the inputs must change only between evaluations and never mid-settle. The bench honours this by driving every input shortly after a bench clock edge and comparing at the opposite edge. The stimulus cycles through all four select codes, including the unused one. It also covers the carry-chain extremes: all-propagate words, an all-zero add, and a carry generated at bit 0 that ends at bit 7.

// File: rtl/alu_kogge_pkg.sv
`timescale 1ns/1ps
package alu_kogge_pkg;

    typedef enum logic [1:0] {
        OP_AND  = 2'b00,
        OP_XOR  = 2'b01,
        OP_ADD  = 2'b10,
        OP_NONE = 2'b11
    } alu_op_e;

endpackage

// File: rtl/alu_pg_stage.sv
`timescale 1ns/1ps
// Per-bit propagate / generate formation.
module alu_pg_stage #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] in_a,
    input  logic [WIDTH-1:0] in_b,
    output logic [WIDTH-1:0] bit_p,
    output logic [WIDTH-1:0] bit_g
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign bit_p[i] = in_a[i] ^ in_b[i];
        assign bit_g[i] = in_a[i] & in_b[i];
    end
endmodule

// File: rtl/alu_prefix_net.sv
`timescale 1ns/1ps
// Kogge-Stone carry network: log2(WIDTH) levels, span doubling per level.
module alu_prefix_net #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] bit_p,
    input  logic [WIDTH-1:0] bit_g,
    output logic [WIDTH-1:0] grp_g,   // generate over bits i..0
    output logic [WIDTH-1:0] grp_p    // propagate over bits i..0
);
    localparam int LEVELS = $clog2(WIDTH);

    logic [WIDTH-1:0] g_lvl [LEVELS+1];
    logic [WIDTH-1:0] p_lvl [LEVELS+1];

    assign g_lvl[0] = bit_g;
    assign p_lvl[0] = bit_p;

    for (genvar l = 0; l < LEVELS; l++) begin : g_level
        localparam int SPAN = 1 << l;
        for (genvar i = 0; i < WIDTH; i++) begin : g_node
            if (i >= SPAN) begin : g_merge
                assign g_lvl[l+1][i] = g_lvl[l][i] | (p_lvl[l][i] & g_lvl[l][i-SPAN]);
                assign p_lvl[l+1][i] = p_lvl[l][i] & p_lvl[l][i-SPAN];
            end else begin : g_pass
                assign g_lvl[l+1][i] = g_lvl[l][i];
                assign p_lvl[l+1][i] = p_lvl[l][i];
            end
        end
    end

    assign grp_g = g_lvl[LEVELS];
    assign grp_p = p_lvl[LEVELS];

    // Group propagate of the full word must mean every bit propagates (R3 carry path).
    always_comb begin
        a_r3_full_propagate: assert (grp_p[WIDTH-1] == (&bit_p))
            else $error("group propagate mismatch");
        a_r7_no_carry_without_generate: assert ((bit_g != '0) || (grp_g == '0))
            else $error("carry created with no generate bit");
    end
endmodule

// File: rtl/alu_sum_stage.sv
`timescale 1ns/1ps
// Sum generator: propagate XOR incoming carry, carry into bit 0 is zero.
module alu_sum_stage #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] bit_p,
    input  logic [WIDTH-1:0] grp_g,
    output logic [WIDTH-1:0] sum,
    output logic             cout
);
    logic [WIDTH-1:0] carry_in_vec;

    assign carry_in_vec = {grp_g[WIDTH-2:0], 1'b0};
    assign sum          = bit_p ^ carry_in_vec;
    assign cout         = grp_g[WIDTH-1];
endmodule

// File: rtl/alu_kogge8.sv
`timescale 1ns/1ps
module alu_kogge8
    import alu_kogge_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [7:0] opnd_a,
    input  logic [7:0] opnd_b,
    input  logic [1:0] op_sel,
    output logic [7:0] result,
    output logic       carry_out
);
    localparam int SUMW = WIDTH + 1;

    typedef struct packed {
        logic [WIDTH-1:0] res;
        logic             cout;
    } alu_out_t;

    logic [WIDTH-1:0] bit_p, bit_g, grp_g, grp_p, sum_w;
    logic             sum_cout;
    alu_out_t         out_d;
    alu_op_e          op_e;

    assign op_e = alu_op_e'(op_sel);

    alu_pg_stage #(.WIDTH(WIDTH)) u_pg (
        .in_a  (opnd_a),
        .in_b  (opnd_b),
        .bit_p (bit_p),
        .bit_g (bit_g)
    );

    alu_prefix_net #(.WIDTH(WIDTH)) u_net (
        .bit_p (bit_p),
        .bit_g (bit_g),
        .grp_g (grp_g),
        .grp_p (grp_p)
    );

    alu_sum_stage #(.WIDTH(WIDTH)) u_sum (
        .bit_p (bit_p),
        .grp_g (grp_g),
        .sum   (sum_w),
        .cout  (sum_cout)
    );

    // Three-way result selector; the spare code yields zero.
    always_comb begin
        out_d = '0;
        unique case (op_e)
            OP_AND:  out_d.res = opnd_a & opnd_b;
            OP_XOR:  out_d.res = bit_p;
            OP_ADD:  begin
                out_d.res  = sum_w;
                out_d.cout = sum_cout;
            end
            default: out_d = '0;
        endcase
    end

    assign result    = out_d.res;
    assign carry_out = out_d.cout;

    // Port-level checks against a behavioural reference.
    always_comb begin
        if (op_sel == 2'b10) begin
            a_r3_add_matches_sum: assert ({carry_out, result} == (SUMW'(opnd_a) + SUMW'(opnd_b)))
                else $error("prefix sum differs from reference");
        end
        if (op_sel != 2'b10) begin
            a_r1_no_carry_logical: assert (carry_out == 1'b0)
                else $error("carry set outside ADD");
        end
        if (op_sel == 2'b11) begin
            a_r4_spare_code_zero: assert (result == '0)
                else $error("spare code gives nonzero result");
        end
        if (op_sel == 2'b01) begin
            a_r2_xor_result: assert ((result ^ opnd_b) == opnd_a)
                else $error("XOR result inconsistent");
        end
    end
endmodule

// File: tb/alu_kogge8_tb.sv
`timescale 1ns/1ps
module alu_kogge8_tb;

    typedef struct {
        logic [7:0] a;
        logic [7:0] b;
        logic [1:0] op;
        logic [7:0] exp_res;
        logic       exp_cout;
        string      req;
    } item_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] opnd_a = '0;
    logic [7:0] opnd_b = '0;
    logic [1:0] op_sel = '0;
    logic [7:0] result;
    logic       carry_out;

    int   total = 0;
    int   bad   = 0;
    bit   done  = 1'b0;
    item_t sb_q[$];

    always #2.5 clk = ~clk;   // 200 MHz

    alu_kogge8 u_dut (
        .opnd_a    (opnd_a),
        .opnd_b    (opnd_b),
        .op_sel    (op_sel),
        .result    (result),
        .carry_out (carry_out)
    );

    function automatic item_t model(input logic [7:0] a, input logic [7:0] b,
                                    input logic [1:0] op, input string req);
        item_t it;
        logic [8:0] s;
        it.a = a; it.b = b; it.op = op; it.req = req;
        s = {1'b0, a} + {1'b0, b};
        case (op)
            2'b00:   begin it.exp_res = a & b; it.exp_cout = 1'b0; end
            2'b01:   begin it.exp_res = a ^ b; it.exp_cout = 1'b0; end
            2'b10:   begin it.exp_res = s[7:0]; it.exp_cout = s[8]; end
            default: begin it.exp_res = 8'h00; it.exp_cout = 1'b0; end
        endcase
        return it;
    endfunction

    // Driver: apply after the rising edge, push the expectation.
    task automatic drive(input logic [7:0] a, input logic [7:0] b,
                         input logic [1:0] op, input string req);
        @(posedge clk);
        #1;
        opnd_a = a; opnd_b = b; op_sel = op;
        sb_q.push_back(model(a, b, op, req));
    endtask

    // Monitor: compare at the falling edge.
    initial begin
        forever begin
            @(negedge clk);
            if (sb_q.size() != 0) begin
                item_t it;
                it = sb_q.pop_front();
                total++;
                if (result !== it.exp_res || carry_out !== it.exp_cout) begin
                    bad++;
                    $display("FAIL %s a=%h b=%h op=%b: got res=%h cout=%b, expected res=%h cout=%b",
                             it.req, it.a, it.b, it.op, result, carry_out,
                             it.exp_res, it.exp_cout);
                end
            end
        end
    end

    // R8: same-step response with no clock edge in between.
    task automatic check_same_step();
        @(posedge clk);
        #1;
        opnd_a = 8'h3C; opnd_b = 8'h0F; op_sel = 2'b10;
        #0.1;
        total++;
        if (result !== 8'h4B || carry_out !== 1'b0) begin
            bad++;
            $display("FAIL R8 got res=%h cout=%b, expected res=4b cout=0", result, carry_out);
        end
        opnd_a = 8'hF0; op_sel = 2'b00;
        #0.1;
        total++;
        if (result !== 8'h00 || carry_out !== 1'b0) begin
            bad++;
            $display("FAIL R8 got res=%h cout=%b, expected res=00 cout=0", result, carry_out);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // Idle inputs: zero operands, AND.
        drive(8'h00, 8'h00, 2'b00, "R1 idle");
        // R5 / R6 worked examples
        drive(8'b10101111, 8'b10000101, 2'b10, "R5");
        drive(8'b10101001, 8'b10000000, 2'b01, "R6");
        // R7 carry chain corners
        drive(8'h00, 8'h00, 2'b10, "R7 zero add");
        drive(8'hFF, 8'h01, 2'b10, "R7 full ripple");
        drive(8'h01, 8'hFF, 2'b10, "R7 full ripple swapped");
        drive(8'hFF, 8'hFF, 2'b10, "R3 max");
        drive(8'h80, 8'h80, 2'b10, "R3 top carry");
        drive(8'h55, 8'hAA, 2'b10, "R3 all propagate");
        // R4 spare code with busy operands
        drive(8'hFF, 8'hFF, 2'b11, "R4");
        drive(8'hA5, 8'h5A, 2'b11, "R4");
        // R1 / R2 with carry-generating operands
        drive(8'hFF, 8'hFF, 2'b00, "R1");
        drive(8'hFF, 8'h81, 2'b01, "R2");
        // Exhaustive sweep of operand a against walking b patterns
        for (int i = 0; i < 256; i++) begin
            drive(8'(i), 8'(i * 37 + 11), 2'b10, "R3 sweep");
        end
        // Random mix over every code
        for (int k = 0; k < 4000; k++) begin
            logic [1:0] op;
            op = 2'(k);
            case (op)
                2'b00:   drive(8'($urandom), 8'($urandom), op, "R1 random");
                2'b01:   drive(8'($urandom), 8'($urandom), op, "R2 random");
                2'b10:   drive(8'($urandom), 8'($urandom), op, "R3 random");
                default: drive(8'($urandom), 8'($urandom), op, "R4 random");
            endcase
        end
        @(posedge clk);
        wait (sb_q.size() == 0);
        @(posedge clk);
        check_same_step();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog
    initial begin
        #(200000 * 5);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule